// File: doc/BRIEF.md
# Signed 8x8 Array Multiplier

This block multiplies two 8-bit two's-complement operands and returns their 16-bit two's-complement product. It starts from a plain AND array of partial-product terms and never sign-extends a row. Instead, a fixed set of terms is inverted and two constant ones are added to the array. These corrections make the unsigned sum of the array equal to the signed product modulo 2^16.

The rows of the array are added by a chain of carry-save stages built from full adders, which leaves one sum vector and one carry vector. A parallel-prefix adder then combines these two vectors into the final product. The whole multiply is combinational. A parameter can place a register on the output, which makes the result available one clock after the operands. Any weight above bit 15 is discarded.

Top module: `smul_array`

## Requirements
- R1: For every pair of 8-bit signed operands, the product equals the signed mathematical product, taken as a 16-bit two's-complement value.
- R2: In each partial-product row for multiplier bits 0 to 6, the term that uses multiplicand bit 7 is inverted. The other terms in these rows are the plain AND of the two bits.
- R3: In the row for multiplier bit 7, every term except the one that uses multiplicand bit 7 is inverted.
- R4: The array contains two constant ones, one at product weight 8 and one at product weight 15. With both operands zero, the product is zero.
- R5: The carry-save reduction keeps the value of the array: its sum vector plus its carry vector, modulo 2^16, equals the sum of all rows.
- R6: The final adder outputs the modulo-2^16 sum of the sum vector and the carry vector.
- R7: With the output register enabled (the default), the product appears one clock edge after the operands are sampled. An active-low asynchronous reset clears the product to 0.
- R8: -128 multiplied by -128 gives 16384 (0x4000).
- R9: A zero operand gives a zero product, whatever the other operand is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| mcand_i | input | 8 | Signed multiplicand |
| mplier_i | input | 8 | Signed multiplier |
| product_o | output | 16 | Signed product |

## Verification
With the default registered output, a product is due at the first rising edge after its operands are applied. The bench drives the operands on a falling edge and reads the product on the next falling edge, which is half a period after that rising edge. This lets a new operand pair go in every cycle: at each falling edge the bench checks the previous pair's result and then applies the next pair. The array, carry-save and final-adder relations have no latency, so the assertions check them against the operands present at the same clock edge.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // Decide whether the AND term at (row, col) enters the array inverted.
  // The top row (multiplier MSB) is a negated row: all but its MSB column flip.
  // Every other row flips only its MSB column.
  function automatic logic term_inverted(input int row, input int col, input int n);
    if (row == n - 1) return (col != n - 1);
    return (col == n - 1);
  endfunction

  // Full-adder compressor: sum output.
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  // Full-adder compressor: carry (majority) output.
  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/smul_ppgen.sv
module smul_ppgen #(
  parameter int N = 8,
  localparam int W = 2 * N,
  localparam int ROWS = N + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             mcand_i,
  input  logic [N-1:0]             mplier_i,
  output logic [ROWS-1:0][W-1:0]   rows_o
);
  import smul_pkg::*;

  // Raw AND terms, indexed [multiplier bit][multiplicand bit].
  logic [N-1:0][N-1:0] and_terms;

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      assign and_terms[r][c] = mcand_i[c] & mplier_i[r];
    end
  end

  always_comb begin
    rows_o = '0;
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        rows_o[r][r + c] = term_inverted(r, c, N) ? ~and_terms[r][c] : and_terms[r][c];
      end
    end
    // Constant correction row: one beside the first row's MSB, one at the top.
    rows_o[N][N]     = 1'b1;
    rows_o[N][W - 1] = 1'b1;
  end

  // Assertion-side view: unsigned sum of every row.
  logic [W-1:0] array_total;
  always_comb begin
    array_total = '0;
    for (int k = 0; k < ROWS; k++) array_total = array_total + rows_o[k];
  end

  logic signed [W-1:0] signed_ref;
  assign signed_ref = W'($signed(mcand_i) * $signed(mplier_i));

  // R2 R3 R4
  array_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    array_total == signed_ref);

endmodule

// File: rtl/smul_csa.sv
module smul_csa #(
  parameter int N = 8,
  localparam int W = 2 * N,
  localparam int ROWS = N + 1,
  localparam int STAGES = ROWS - 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ROWS-1:0][W-1:0]   rows_i,
  output logic [W-1:0]             sum_o,
  output logic [W-1:0]             carry_o
);
  import smul_pkg::*;

  // Saved-carry pair after each stage; index 0 holds the first two rows.
  logic [W-1:0] acc_s [0:STAGES];
  logic [W-1:0] acc_c [0:STAGES];

  assign acc_s[0] = rows_i[0];
  assign acc_c[0] = rows_i[1];

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    logic [W-1:0] maj;
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign acc_s[k][i] = fa_sum(acc_s[k-1][i], acc_c[k-1][i], rows_i[k+1][i]);
      assign maj[i]      = fa_carry(acc_s[k-1][i], acc_c[k-1][i], rows_i[k+1][i]);
    end
    // Carries move up one weight; the one leaving bit W-1 is dropped.
    assign acc_c[k] = {maj[W-2:0], 1'b0};
  end

  assign sum_o   = acc_s[STAGES];
  assign carry_o = acc_c[STAGES];

  logic [W-1:0] rows_total;
  always_comb begin
    rows_total = '0;
    for (int k = 0; k < ROWS; k++) rows_total = rows_total + rows_i[k];
  end

  // R5
  csa_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    W'(sum_o + carry_o) == rows_total);

endmodule

// File: rtl/smul_cpa.sv
module smul_cpa #(
  parameter int W = 16,
  localparam int LEVELS = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  // Parallel-prefix generate/propagate, one row per level.
  logic [W-1:0] gen [0:LEVELS];
  logic [W-1:0] prp [0:LEVELS];
  logic [W-1:0] carry_in;

  assign gen[0] = x_i & y_i;
  assign prp[0] = x_i ^ y_i;

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int DIST = 1 << (l - 1);
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= DIST) begin : g_merge
        assign gen[l][i] = gen[l-1][i] | (prp[l-1][i] & gen[l-1][i-DIST]);
        assign prp[l][i] = prp[l-1][i] & prp[l-1][i-DIST];
      end else begin : g_pass
        assign gen[l][i] = gen[l-1][i];
        assign prp[l][i] = prp[l-1][i];
      end
    end
  end

  assign carry_in = {gen[LEVELS][W-2:0], 1'b0};
  assign sum_o    = prp[0] ^ carry_in;

  // R6
  cpa_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_o == W'(x_i + y_i));

endmodule

// File: rtl/smul_array.sv
module smul_array #(
  parameter int N = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int W = 2 * N,
  localparam int ROWS = N + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  output logic [W-1:0] product_o
);
  localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};
  localparam logic [W-1:0] MOST_NEG_SQ = {2'b01, {(W-2){1'b0}}};

  logic [ROWS-1:0][W-1:0] pp_rows;
  logic [W-1:0]           cs_sum;
  logic [W-1:0]           cs_carry;
  logic [W-1:0]           comb_prod;

  smul_ppgen #(.N(N)) u_ppgen (
    .clk(clk), .rst_n(rst_n),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .rows_o(pp_rows)
  );

  smul_csa #(.N(N)) u_csa (
    .clk(clk), .rst_n(rst_n),
    .rows_i(pp_rows),
    .sum_o(cs_sum), .carry_o(cs_carry)
  );

  smul_cpa #(.W(W)) u_cpa (
    .clk(clk), .rst_n(rst_n),
    .x_i(cs_sum), .y_i(cs_carry),
    .sum_o(comb_prod)
  );

  if (REG_OUT) begin : g_reg
    logic [W-1:0] prod_q;
    logic         primed;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q <= '0;
        primed <= 1'b0;
      end else begin
        prod_q <= comb_prod;
        primed <= 1'b1;
      end
    end
    assign product_o = prod_q;

    // R7
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> product_o == $past(comb_prod));
  end else begin : g_comb
    assign product_o = comb_prod;
  end

  // R1
  signed_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comb_prod == W'($signed(mcand_i) * $signed(mplier_i)));

  // R8
  most_neg_sq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mcand_i == MOST_NEG && mplier_i == MOST_NEG) |-> comb_prod == MOST_NEG_SQ);

  // R9
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mcand_i == '0 || mplier_i == '0) |-> comb_prod == '0);

endmodule

// File: tb/smul_array_tb.sv
module smul_array_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mcand = '0;
  logic [7:0]  mplier = '0;
  logic [15:0] product;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  smul_array u_dut (
    .clk(clk), .rst_n(rst_n),
    .mcand_i(mcand), .mplier_i(mplier),
    .product_o(product)
  );

  // Sign-magnitude shift-and-add model, independent of the array scheme.
  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    int ma = a[7] ? 256 - int'(a) : int'(a);
    int mb = b[7] ? 256 - int'(b) : int'(b);
    int acc = 0;
    for (int i = 0; i < 9; i++) if (mb[i]) acc = acc + (ma << i);
    if (a[7] ^ b[7]) acc = -acc;
    return 16'(acc);
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: a=%0d b=%0d got=%h expected=%h", req,
               $signed(mcand), $signed(mplier), got, exp);
    end
  endtask

  // Apply one pair on a falling edge, read it on the next falling edge.
  task automatic apply(input string req, input logic [7:0] a, input logic [7:0] b);
    mcand  = a;
    mplier = b;
    @(negedge clk);
    check(req, product, ref_mul(a, b));
  endtask

  task automatic t_reset();
    mcand = 8'h7F; mplier = 8'h7F;
    @(negedge clk);
    check("R7 reset", product, 16'h0000);
    rst_n = 1'b1;
    mcand = 8'h05; mplier = 8'hFD;
    @(negedge clk);
    check("R7 latency", product, 16'hFFF1);
  endtask

  task automatic t_corners();
    apply("R8", 8'h80, 8'h80);
    check("R8 value", product, 16'h4000);
    apply("R4 zero", 8'h00, 8'h00);
    apply("R9", 8'h00, 8'h80);
    apply("R9", 8'h7F, 8'h00);
    apply("R2", 8'h80, 8'h01);
    apply("R2", 8'h80, 8'h7F);
    apply("R3", 8'h01, 8'h80);
    apply("R3", 8'h7F, 8'h80);
    apply("R1", 8'h7F, 8'h7F);
    apply("R1", 8'hFF, 8'hFF);
  endtask

  task automatic t_exhaustive();
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        apply("R1 R5 R6", 8'(a), 8'(b));
        if (done) return;
      end
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_corners();
    t_exhaustive();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got=%0d cycles expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule